// File: doc/BRIEF.md
# Reservation Station Issue Array

This block is a small pool of reservation station entries placed in front of a single functional unit. An upstream instruction queue offers decoded instructions one at a time, in program order, through a valid/ready handshake. The block places each accepted instruction in a free entry and tells the issuer which station tag the instruction received. Each source operand arrives either as a finished value or as the tag of the station that will produce it. Tag zero means no producer is pending.

Entries that are waiting on a tag watch a shared result broadcast bus. When the tag on the bus matches, the entry copies the broadcast value and drops the tag. An entry whose two operands both hold values can be sent to the functional unit. The block offers one such entry per cycle on the dispatch port, and the oldest ready entry goes first. As a result, a later independent instruction can run ahead of an earlier one that is still waiting on a producer.

Top module: `rs_issue_array`

## Requirements
- R1: After synchronous reset every entry is free, `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An instruction is accepted on a clock edge where `iss_valid` and `iss_ready` are both 1. While `iss_valid` is high, `iss_tag` shows the tag the instruction will receive, which is `BASE_TAG` plus the index of the lowest free entry (1 for entry 0 by default).
- R3: While all entries are busy, `iss_ready` is 0 and an offered instruction is not accepted. Issue stalls until an entry frees.
- R4: A source operand given with tag 0 is stored as its value and later appears unchanged on `dsp_vj` or `dsp_vk`, together with the instruction's `dsp_op`.
- R5: An entry with a non-zero operand tag is not offered for dispatch until that tag has been resolved.
- R6: A broadcast with `bc_valid` 1 fills every waiting operand, in either operand slot, whose tag equals `bc_tag`. A broadcast with a different tag leaves the operand waiting.
- R7: A broadcast that occurs in the same cycle as an issue whose operand tag matches it is captured by the issuing instruction.
- R8: Among several ready entries, the one issued earliest is offered first, regardless of which entry index it occupies. Only one entry is offered per cycle.
- R9: An entry is freed on the edge where `dsp_valid` and `dsp_ready` are both 1. While `dsp_ready` is 0, the offered entry stays valid with the same fields.
- R10: Take a divide, then an add that needs the divide's result, then an independent subtract. After the divide dispatches, the subtract dispatches before the add, and the add dispatches only after the divide's tag has been broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction queue head is valid |
| iss_ready | output | 1 | A free entry exists, so the head can be accepted |
| iss_op | input | OP_W | Operation code |
| iss_vj | input | DATA_W | First operand value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | First operand producer tag, 0 if the value is present |
| iss_vk | input | DATA_W | Second operand value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | Second operand producer tag, 0 if the value is present |
| iss_tag | output | TAG_W | Tag given to the instruction being offered |
| bc_valid | input | 1 | Result broadcast is valid this cycle |
| bc_tag | input | TAG_W | Tag of the broadcasting station |
| bc_value | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | A ready entry is offered to the functional unit |
| dsp_ready | input | 1 | Functional unit takes the offered entry |
| dsp_op | output | OP_W | Operation code of the offered entry |
| dsp_vj | output | DATA_W | First operand of the offered entry |
| dsp_vk | output | DATA_W | Second operand of the offered entry |
| dsp_tag | output | TAG_W | Station tag of the offered entry |

## Verification
The bench builds an age inversion: the younger of two ready instructions sits in the lower entry index. A picker that uses index priority would then dispatch the wrong one first. It drives a broadcast in the same cycle as an issue that names that tag. A design without the bypass leaves the entry waiting forever, so `dsp_valid` never rises. It fills every entry with waiting instructions and offers one more. A design that ignores the full condition would overwrite an entry or dispatch a fifth instruction. The divide/add/subtract sequence shows whether a dependent instruction is wrongly let through before its producer broadcasts.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned TAG_W  = 3;

    localparam logic [TAG_W-1:0] NO_TAG = '0;

    // Source operand slot: tag == NO_TAG means val holds the operand.
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } operand_t;

    typedef struct packed {
        logic              busy;
        logic [OP_W-1:0]   op;
        operand_t          src_a;
        operand_t          src_b;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } bcast_t;

    // Resolve an operand against the broadcast bus.
    function automatic operand_t snoop(operand_t cur, bcast_t bc);
        operand_t res;
        res = cur;
        if (bc.valid && (cur.tag != NO_TAG) && (cur.tag == bc.tag)) begin
            res.tag = NO_TAG;
            res.val = bc.value;
        end
        return res;
    endfunction

    function automatic logic operands_ready(slot_t s);
        return s.busy && (s.src_a.tag == NO_TAG) && (s.src_b.tag == NO_TAG);
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  logic [OP_W-1:0] new_op,
    input  operand_t        new_a,
    input  operand_t        new_b,
    input  bcast_t          bc,
    input  logic            release_i,
    output slot_t           state,
    output logic            ready
);

    slot_t state_d;

    always_comb begin
        state_d = state;
        if (alloc) begin
            state_d.busy  = 1'b1;
            state_d.op    = new_op;
            state_d.src_a = snoop(new_a, bc);
            state_d.src_b = snoop(new_b, bc);
        end else begin
            if (release_i) begin
                state_d.busy = 1'b0;
            end
            state_d.src_a = snoop(state.src_a, bc);
            state_d.src_b = snoop(state.src_b, bc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            state <= state_d;
        end
    end

    assign ready = operands_ready(state);

endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int unsigned DEPTH = 4
) (
    input  logic [DEPTH-1:0] busy,
    output logic [DEPTH-1:0] pick_oh,
    output logic             any_free
);

    always_comb begin
        logic found;
        found   = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!busy[i] && !found) begin
                pick_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
        any_free = found;
    end

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] alloc_oh,
    input  logic [DEPTH-1:0] ready,
    output logic [DEPTH-1:0] grant_oh
);

    // older_q[j][i] set: entry j was allocated before entry i.
    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (alloc_oh[k]) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        older_q[k][j] <= 1'b0;
                        if (j != k) begin
                            older_q[j][k] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if ((j != i) && ready[j] && older_q[j][i]) begin
                    beaten = 1'b1;
                end
            end
            grant_oh[i] = ready[i] && !beaten;
        end
    end

endmodule

// File: rtl/rs_issue_array.sv
module rs_issue_array
    import rs_pkg::*;
#(
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned BASE_TAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              dsp_valid,
    input  logic              dsp_ready,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_vj,
    output logic [DATA_W-1:0] dsp_vk,
    output logic [TAG_W-1:0]  dsp_tag
);

    localparam int unsigned LAST_TAG = BASE_TAG + DEPTH - 1;

    slot_t [DEPTH-1:0] slots;
    logic  [DEPTH-1:0] busy_vec;
    logic  [DEPTH-1:0] ready_vec;
    logic  [DEPTH-1:0] free_oh;
    logic  [DEPTH-1:0] alloc_vec;
    logic  [DEPTH-1:0] grant_vec;
    logic  [DEPTH-1:0] release_vec;
    logic              issue_fire;
    bcast_t            bc;
    operand_t          new_a;
    operand_t          new_b;

    assign bc.valid = bc_valid;
    assign bc.tag   = bc_tag;
    assign bc.value = bc_value;

    assign new_a.tag = iss_qj;
    assign new_a.val = iss_vj;
    assign new_b.tag = iss_qk;
    assign new_b.val = iss_vk;

    rs_free_pick #(.DEPTH(DEPTH)) i_free (
        .busy     (busy_vec),
        .pick_oh  (free_oh),
        .any_free (iss_ready)
    );

    assign issue_fire  = iss_valid && iss_ready;
    assign alloc_vec   = issue_fire ? free_oh : '0;
    assign release_vec = dsp_ready ? grant_vec : '0;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            rs_slot i_slot (
                .clk       (clk),
                .rst       (rst),
                .alloc     (alloc_vec[g]),
                .new_op    (iss_op),
                .new_a     (new_a),
                .new_b     (new_b),
                .bc        (bc),
                .release_i (release_vec[g]),
                .state     (slots[g]),
                .ready     (ready_vec[g])
            );
            assign busy_vec[g] = slots[g].busy;
        end
    endgenerate

    rs_age_pick #(.DEPTH(DEPTH)) i_age (
        .clk      (clk),
        .rst      (rst),
        .alloc_oh (alloc_vec),
        .ready    (ready_vec),
        .grant_oh (grant_vec)
    );

    // Tag offered to the issuer: station number of the lowest free entry.
    always_comb begin
        iss_tag = NO_TAG;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_oh[i]) begin
                iss_tag = TAG_W'(BASE_TAG + i);
            end
        end
    end

    // Dispatch mux driven by the one-hot grant.
    always_comb begin
        dsp_valid = |grant_vec;
        dsp_op    = '0;
        dsp_vj    = '0;
        dsp_vk    = '0;
        dsp_tag   = NO_TAG;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant_vec[i]) begin
                dsp_op  = dsp_op  | slots[i].op;
                dsp_vj  = dsp_vj  | slots[i].src_a.val;
                dsp_vk  = dsp_vk  | slots[i].src_b.val;
                dsp_tag = dsp_tag | TAG_W'(BASE_TAG + i);
            end
        end
    end

    initial begin
        if (BASE_TAG == 0 || LAST_TAG >= (1 << TAG_W)) begin
            $display("rs_issue_array: station tags do not fit TAG_W");
        end
    end

endmodule

// File: rtl/rs_issue_array_chk.sv
module rs_issue_array_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic             dsp_valid,
    input logic             dsp_ready,
    input logic [DEPTH-1:0] busy_vec,
    input logic [DEPTH-1:0] grant_vec
);

    // R1: the first cycle out of reset is idle
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (busy_vec == '0 && !dsp_valid && iss_ready));

    // R2: an accepted issue without a dispatch adds one busy entry
    p_accept_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !(dsp_valid && dsp_ready))
        |=> (int'($countones(busy_vec)) == int'($past($countones(busy_vec))) + 1));

    // R3: a full pool refuses issue
    p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (&busy_vec) |-> !iss_ready);

    // R5: only busy entries are offered
    p_grant_busy_r5: assert property (@(posedge clk) disable iff (rst)
        ((grant_vec & ~busy_vec) == '0) && (dsp_valid == (|grant_vec)));

    // R8: at most one entry offered per cycle
    p_grant_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    // R9: the taken entry is free afterwards
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && dsp_ready) |=> (($past(grant_vec) & busy_vec) == '0));

    // R9: an offer not taken stays offered
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && !dsp_ready) |=> dsp_valid);

endmodule

bind rs_issue_array rs_issue_array_chk #(.DEPTH(DEPTH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .dsp_valid (dsp_valid),
    .dsp_ready (dsp_ready),
    .busy_vec  (busy_vec),
    .grant_vec (grant_vec)
);

// File: tb/test_rs_issue_array.sv
module test_rs_issue_array;
    import rs_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              iss_valid;
    logic              iss_ready;
    logic [OP_W-1:0]   iss_op;
    logic [DATA_W-1:0] iss_vj;
    logic [TAG_W-1:0]  iss_qj;
    logic [DATA_W-1:0] iss_vk;
    logic [TAG_W-1:0]  iss_qk;
    logic [TAG_W-1:0]  iss_tag;
    logic              bc_valid;
    logic [TAG_W-1:0]  bc_tag;
    logic [DATA_W-1:0] bc_value;
    logic              dsp_valid;
    logic              dsp_ready;
    logic [OP_W-1:0]   dsp_op;
    logic [DATA_W-1:0] dsp_vj;
    logic [DATA_W-1:0] dsp_vk;
    logic [TAG_W-1:0]  dsp_tag;

    int checks = 0;
    int errors = 0;

    rs_issue_array i_rs_issue_array (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
        .dsp_vj(dsp_vj), .dsp_vk(dsp_vk), .dsp_tag(dsp_tag)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic issue(input logic [OP_W-1:0] op, input logic [31:0] vj, input logic [TAG_W-1:0] qj,
                         input logic [31:0] vk, input logic [TAG_W-1:0] qk,
                         input logic [TAG_W-1:0] exp_tag, input string req);
        iss_valid = 1'b1; iss_op = op;
        iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
        #1;
        chk(iss_ready === 1'b1, req, 32'(iss_ready), 32'd1);
        chk(iss_tag === exp_tag, req, 32'(iss_tag), 32'(exp_tag));
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic take(input logic [TAG_W-1:0] tag, input logic [OP_W-1:0] op,
                        input logic [31:0] vj, input logic [31:0] vk, input string req);
        #1;
        chk(dsp_valid === 1'b1, req, 32'(dsp_valid), 32'd1);
        chk(dsp_tag === tag, req, 32'(dsp_tag), 32'(tag));
        chk(dsp_op === op, req, 32'(dsp_op), 32'(op));
        chk(dsp_vj === vj, req, dsp_vj, vj);
        chk(dsp_vk === vk, req, dsp_vk, vk);
        dsp_ready = 1'b1;
        @(negedge clk);
        dsp_ready = 1'b0;
    endtask

    task automatic broadcast(input logic [TAG_W-1:0] tag, input logic [31:0] val);
        bc_valid = 1'b1; bc_tag = tag; bc_value = val;
        @(negedge clk);
        bc_valid = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        #1;
        chk(dsp_valid === 1'b0, req, 32'(dsp_valid), 32'd0);
    endtask

    task automatic t_reset();
        #1;
        chk(iss_ready === 1'b1, "R1 ready", 32'(iss_ready), 32'd1);
        chk(dsp_valid === 1'b0, "R1 idle", 32'(dsp_valid), 32'd0);
    endtask

    task automatic t_plain_values();
        issue(4'd1, 32'd10, '0, 32'd20, '0, 3'd1, "R2 tag");
        for (int c = 0; c < 2; c++) begin
            #1;
            chk(dsp_valid === 1'b1 && dsp_vj === 32'd10, "R9 hold", dsp_vj, 32'd10);
            @(negedge clk);
        end
        take(3'd1, 4'd1, 32'd10, 32'd20, "R4 values");
        expect_idle("R9 freed");
    endtask

    task automatic t_div_add_sub();
        issue(4'd3, 32'd100, '0, 32'd4, '0, 3'd1, "R10 div");
        issue(4'd1, 32'd0, 3'd1, 32'd8, '0, 3'd2, "R10 add");
        issue(4'd2, 32'd30, '0, 32'd14, '0, 3'd3, "R10 sub");
        take(3'd1, 4'd3, 32'd100, 32'd4, "R10 div first");
        take(3'd3, 4'd2, 32'd30, 32'd14, "R10 sub before add");
        expect_idle("R5 add waits");
        broadcast(3'd1, 32'd99);
        take(3'd2, 4'd1, 32'd99, 32'd8, "R6 add woken");
        expect_idle("R10 drained");
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) begin
            issue(OP_W'(i + 8), 32'd0, 3'd7, 32'(i * 3), '0, TAG_W'(i + 1), "R2 fill");
        end
        #1;
        chk(iss_ready === 1'b0, "R3 full", 32'(iss_ready), 32'd0);
        iss_valid = 1'b1; iss_op = 4'd15; iss_qj = '0; iss_qk = '0;
        @(negedge clk);
        iss_valid = 1'b0;
        expect_idle("R5 all waiting");
        broadcast(3'd7, 32'd5);
        for (int i = 0; i < 4; i++) begin
            take(TAG_W'(i + 1), OP_W'(i + 8), 32'd5, 32'(i * 3), "R3 order");
        end
        expect_idle("R3 no extra");
    endtask

    task automatic t_bypass();
        bc_valid = 1'b1; bc_tag = 3'd6; bc_value = 32'h55;
        issue(4'd7, 32'd0, 3'd6, 32'd0, 3'd5, 3'd1, "R7 issue");
        bc_valid = 1'b0;
        expect_idle("R6 other tag waits");
        broadcast(3'd5, 32'h66);
        take(3'd1, 4'd7, 32'h55, 32'h66, "R7 bypass");
    endtask

    task automatic t_age();
        issue(4'd4, 32'd1, '0, 32'd2, '0, 3'd1, "R8 A");
        issue(4'd5, 32'd0, 3'd7, 32'd3, '0, 3'd2, "R8 B");
        take(3'd1, 4'd4, 32'd1, 32'd2, "R8 A out");
        issue(4'd6, 32'd9, '0, 32'd9, '0, 3'd1, "R8 C reuses entry 0");
        broadcast(3'd7, 32'h77);
        take(3'd2, 4'd5, 32'h77, 32'd3, "R8 older first");
        take(3'd1, 4'd6, 32'd9, 32'd9, "R8 younger next");
        expect_idle("R8 drained");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; iss_valid = 1'b0; iss_op = '0; iss_vj = '0; iss_qj = '0;
        iss_vk = '0; iss_qk = '0; bc_valid = 1'b0; bc_tag = '0; bc_value = '0;
        dsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain_values();
        t_div_add_sub();
        t_full();
        t_bypass();
        t_age();
        finish_run();
    end

endmodule